// File: doc/BRIEF.md
# Rotating Interrupt Request Scanner

This block accepts a set of asynchronous interrupt request lines and turns them into one outgoing request at a time for a downstream message sender. Each line has its own settings: a mask, a level or edge trigger, an active level, a 3-bit delivery mode and an 8-bit vector. Each line input goes through a two-flop synchronizer. The input is then corrected for polarity and sent to an edge detector or a level qualifier. A detected request sets the line's delivery-status flag, and that flag holds until the sender accepts the message.

Pending lines are visited in a rotating order that starts just after the last line sent. Line number and vector carry no priority. The chosen request is held on a valid/accept handshake until it is taken. Level-triggered lines keep a remote-IRR flag that is set when their message is accepted. An end-of-interrupt strobe carrying a matching vector clears that flag. The highest line can also be bypassed: while it is masked, its polarity-corrected input drives an active-low SMI output.

Top module: `irq_rotor`

## Requirements
- R1: With `cfg_lowact[i]`=0 a line is active when its input is 1. With `cfg_lowact[i]`=1 it is active when its input is 0. Only a change into the active state counts as an edge.
- R2: An edge-triggered line is detected only if its input stays active for at least two consecutive clock samples. An input that is active for one sample is ignored.
- R3: A detected line sets `pend_o[i]`. Further edges on that line produce no extra delivery until the pending request is accepted. Acceptance clears `pend_o[i]`.
- R4: While `cfg_mask[i]`=1, activity on line i sets nothing. It is also not held pending, so unmasking later produces no request.
- R5: A level-triggered line (`cfg_level[i]`=1) becomes pending only while it is active, unmasked, and its remote-IRR is clear. It becomes pending again after remote-IRR clears if it is still active.
- R6: Accepting a level-triggered line sets `rirr_o[i]`. An end-of-interrupt strobe clears it only when `eoi_vec` equals the line's vector. An end-of-interrupt strobe with any other vector leaves it set.
- R7: Pending lines are offered in rotating order. The search starts at the line after the last line accepted, wraps past line N-1 to line 0, and takes the first pending unmasked line it finds.
- R8: While `req_valid`=1 and `req_accept`=0, the offered `req_line`, `req_vec` and `req_mode` stay unchanged, even if the configuration changes.
- R9: A line whose delivery mode is 3'b100 (NMI) or 3'b101 (INIT) is treated as edge-triggered even with `cfg_level[i]`=1. It never sets remote-IRR and is offered once per edge.
- R10: While line N-1 is masked, `smi_n` equals the inverse of its synchronized, polarity-corrected activity. While it is unmasked, `smi_n` stays 1 and the line is scanned like any other.
- R11: After reset, `req_valid`=0, `smi_n`=1, and all `pend_o` and `rirr_o` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N | Raw asynchronous request lines |
| cfg_mask | input | N | Per-line mask (1 = masked) |
| cfg_level | input | N | Per-line trigger (1 = level, 0 = edge) |
| cfg_lowact | input | N | Per-line polarity (1 = active low) |
| cfg_mode | input | 3*N | Per-line delivery mode, line i at bits [3i+2:3i] |
| cfg_vec | input | VW*N | Per-line vector, line i at bits [VW*i+VW-1:VW*i] |
| req_valid | output | 1 | Offer present |
| req_line | output | $clog2(N) | Offered line index |
| req_vec | output | VW | Offered vector |
| req_mode | output | 3 | Offered delivery mode |
| req_accept | input | 1 | Sender accepts the offer this cycle |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VW | Vector carried by the end-of-interrupt |
| pend_o | output | N | Per-line delivery-status flags |
| rirr_o | output | N | Per-line remote-IRR flags |
| smi_n | output | 1 | Active-low bypass output of line N-1 |

## Verification
The hardest state to reach from the ports is several lines pending at once while the rotation pointer sits in the middle of the range. The stimulus first accepts a chosen line so that the pointer is placed there. It then fires three lines in the same cycle, so the bench's own distance-from-pointer ordering decides which line must come out first. A second hard case is a level line that is still active while its remote-IRR is set. That state is held across a non-matching end-of-interrupt, and only the matching vector may release a second offer.

// File: rtl/irq_rotor_pkg.sv
package irq_rotor_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWEST = 3'b001,
        DM_SMI    = 3'b010,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_EXT    = 3'b111
    } dmode_e;

    // Modes that always behave as edge-triggered
    function automatic logic forced_edge(input logic [2:0] m);
        return (m == DM_NMI) || (m == DM_INIT);
    endfunction

    typedef struct packed {
        logic [1:0] hist;
        logic       dstat;
        logic       rirr;
    } cell_st_t;

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [1:0] s_d, s_q;

    always_comb begin
        s_d = {s_q[0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q[1];
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_rotor_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic          mask,
    input  logic          level,
    input  logic          lowact,
    input  logic [2:0]    mode,
    input  logic [VW-1:0] vec,
    input  logic          grant,
    input  logic          eoi_valid,
    input  logic [VW-1:0] eoi_vec,
    output logic          act_o,
    output logic          pend_o,
    output logic          rirr_o
);
    logic     synced, act, lvl, edge_hit;
    cell_st_t st_d, st_q;

    irq_sync2 u_sync (.clk(clk), .rst_n(rst_n), .d(raw), .q(synced));

    assign act = synced ^ lowact;
    assign lvl = level & ~forced_edge(mode);
    assign edge_hit = act & st_q.hist[0] & ~st_q.hist[1];

    always_comb begin
        st_d      = st_q;
        st_d.hist = {st_q.hist[0], act};
        if (grant)
            st_d.dstat = 1'b0;
        else if (!mask && !st_q.dstat)
            st_d.dstat = lvl ? (act & ~st_q.rirr) : edge_hit;
        if (!lvl)
            st_d.rirr = 1'b0;
        else if (grant)
            st_d.rirr = 1'b1;
        else if (eoi_valid && eoi_vec == vec)
            st_d.rirr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o  = act;
    assign pend_o = st_q.dstat;
    assign rirr_o = st_q.rirr;

    // R3
    dstat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dstat && !grant |=> st_q.dstat);
    // R4
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask && !st_q.dstat && !grant |=> !st_q.dstat);
    // R6
    rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant && lvl |=> st_q.rirr);
    // R9
    forced_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant && forced_edge(mode) |=> !st_q.rirr);
endmodule

// File: rtl/irq_rotor_pick.sv
module irq_rotor_pick #(
    parameter int N  = 24,
    parameter int VW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pend,
    input  logic [N-1:0]    mask,
    input  logic [N*VW-1:0] cfg_vec,
    input  logic [N*3-1:0]  cfg_mode,
    input  logic            req_accept,
    output logic            req_valid,
    output logic [IW-1:0]   req_line,
    output logic [VW-1:0]   req_vec,
    output logic [2:0]      req_mode,
    output logic [N-1:0]    grant_o
);
    typedef struct packed {
        logic          valid;
        logic [IW-1:0] line;
        logic [VW-1:0] vec;
        logic [2:0]    mode;
        logic [IW-1:0] ptr;
    } pk_t;

    pk_t           pk_d, pk_q;
    logic          grant, found;
    logic [IW-1:0] sel;

    assign grant = pk_q.valid & req_accept;

    // Rotating search from the pointer, first eligible line wins
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(pk_q.ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && pend[idx] && !mask[idx]) begin
                found = 1'b1;
                sel   = IW'(idx);
            end
        end
    end

    always_comb begin
        pk_d = pk_q;
        if (grant) begin
            pk_d.valid = 1'b0;
            pk_d.ptr   = (pk_q.line == IW'(N-1)) ? '0 : pk_q.line + 1'b1;
        end else if (!pk_q.valid && found) begin
            pk_d.valid = 1'b1;
            pk_d.line  = sel;
            pk_d.vec   = cfg_vec[int'(sel)*VW +: VW];
            pk_d.mode  = cfg_mode[int'(sel)*3 +: 3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign req_valid = pk_q.valid;
    assign req_line  = pk_q.line;
    assign req_vec   = pk_q.vec;
    assign req_mode  = pk_q.mode;
    assign grant_o   = grant ? ({{(N-1){1'b0}}, 1'b1} << pk_q.line) : '0;

    // R8
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_accept |=> req_valid && $stable(req_line)
                                     && $stable(req_vec) && $stable(req_mode));
    // R7
    offer_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> pend[req_line]);
endmodule

// File: rtl/irq_rotor.sv
module irq_rotor #(
    parameter int N        = 24,
    parameter int VW       = 8,
    parameter int SMI_LINE = N - 1,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    irq_in,
    input  logic [N-1:0]    cfg_mask,
    input  logic [N-1:0]    cfg_level,
    input  logic [N-1:0]    cfg_lowact,
    input  logic [N*3-1:0]  cfg_mode,
    input  logic [N*VW-1:0] cfg_vec,
    output logic            req_valid,
    output logic [IW-1:0]   req_line,
    output logic [VW-1:0]   req_vec,
    output logic [2:0]      req_mode,
    input  logic            req_accept,
    input  logic            eoi_valid,
    input  logic [VW-1:0]   eoi_vec,
    output logic [N-1:0]    pend_o,
    output logic [N-1:0]    rirr_o,
    output logic            smi_n
);
    logic [N-1:0] act, grant;

    for (genvar i = 0; i < N; i++) begin : g_line
        irq_line_cell #(.VW(VW)) u_cell (
            .clk(clk), .rst_n(rst_n), .raw(irq_in[i]),
            .mask(cfg_mask[i]), .level(cfg_level[i]), .lowact(cfg_lowact[i]),
            .mode(cfg_mode[i*3 +: 3]), .vec(cfg_vec[i*VW +: VW]),
            .grant(grant[i]), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
            .act_o(act[i]), .pend_o(pend_o[i]), .rirr_o(rirr_o[i])
        );
    end

    irq_rotor_pick #(.N(N), .VW(VW)) u_pick (
        .clk(clk), .rst_n(rst_n), .pend(pend_o), .mask(cfg_mask),
        .cfg_vec(cfg_vec), .cfg_mode(cfg_mode), .req_accept(req_accept),
        .req_valid(req_valid), .req_line(req_line), .req_vec(req_vec),
        .req_mode(req_mode), .grant_o(grant)
    );

    assign smi_n = cfg_mask[SMI_LINE] ? ~act[SMI_LINE] : 1'b1;

    // R10
    smi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_n |-> !pend_o[SMI_LINE] || !$past(cfg_mask[SMI_LINE]) || $past(pend_o[SMI_LINE]));
    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: tb/sim_irq_rotor.sv
module sim_irq_rotor;
    localparam int N  = 24;
    localparam int VW = 8;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_in = '0, cfg_mask = '0, cfg_level = '0, cfg_lowact = '0;
    logic [N*3-1:0]  cfg_mode = '0;
    logic [N*VW-1:0] cfg_vec = '0;
    logic            req_valid, req_accept = 1'b0, eoi_valid = 1'b0, smi_n;
    logic [IW-1:0]   req_line;
    logic [VW-1:0]   req_vec, eoi_vec = '0;
    logic [2:0]      req_mode;
    logic [N-1:0]    pend_o, rirr_o;

    int total = 0, bad = 0, bp = 0;

    always #2.5 clk = ~clk;

    irq_rotor #(.N(N), .VW(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_mask(cfg_mask),
        .cfg_level(cfg_level), .cfg_lowact(cfg_lowact), .cfg_mode(cfg_mode),
        .cfg_vec(cfg_vec), .req_valid(req_valid), .req_line(req_line),
        .req_vec(req_vec), .req_mode(req_mode), .req_accept(req_accept),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .pend_o(pend_o),
        .rirr_o(rirr_o), .smi_n(smi_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [N-1:0] lines);
        irq_in = irq_in ^ lines;
        tick(3);
        irq_in = irq_in ^ lines;
    endtask

    task automatic wait_offer(input int line, input int vec, input string tag);
        int w = 0;
        while (!req_valid && w < 30) begin tick(1); w++; end
        check(req_valid, {tag, " valid"}, int'(req_valid), 1);
        check(int'(req_line) == line, {tag, " line"}, int'(req_line), line);
        check(int'(req_vec) == vec, {tag, " vec"}, int'(req_vec), vec);
    endtask

    task automatic accept();
        req_accept = 1'b1;
        bp = (int'(req_line) + 1) % N;
        tick(1);
        req_accept = 1'b0;
    endtask

    task automatic eoi(input int v);
        eoi_vec = VW'(v); eoi_valid = 1'b1;
        tick(1);
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            cfg_vec[i*VW +: VW] = VW'((i * 9 + 1) % 256);
            cfg_mode[i*3 +: 3]  = 3'(i % 4);
        end
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R11 reset state
        check(!req_valid, "R11 req_valid", int'(req_valid), 0);
        check(smi_n, "R11 smi_n", int'(smi_n), 1);
        check(pend_o == '0 && rirr_o == '0, "R11 flags", int'(pend_o), 0);

        // R3 sweep of every line, edge mode, active high (R1)
        for (int i = 0; i < N; i++) begin
            pulse(N'(1) << i);
            wait_offer(i, (i * 9 + 1) % 256, "R1 R3 sweep");
            check(int'(req_mode) == i % 4, "R3 mode", int'(req_mode), i % 4);
            accept();
            check(!pend_o[i] && !req_valid, "R3 cleared", int'(pend_o[i]), 0);
        end

        // R1 active-low on all lines: switch under mask so nothing is held
        cfg_mask = '1; irq_in = '1; tick(5);
        cfg_lowact = '1; tick(5); cfg_mask = '0; tick(5);
        check(!req_valid && pend_o == '0, "R1 no spurious", int'(pend_o), 0);
        for (int i = 0; i < N; i++) begin
            pulse(N'(1) << i);
            wait_offer(i, (i * 9 + 1) % 256, "R1 lowact");
            accept();
        end
        cfg_mask = '1; irq_in = '0; tick(5);
        cfg_lowact = '0; tick(5); cfg_mask = '0; tick(5);
        check(!req_valid && pend_o == '0, "R1 restore", int'(pend_o), 0);

        // R2 one-sample pulse ignored
        irq_in[3] = 1'b1; tick(1); irq_in[3] = 1'b0; tick(10);
        check(!req_valid && !pend_o[3], "R2 short pulse", int'(pend_o[3]), 0);

        // R4 masked edge neither delivered nor held
        cfg_mask[11] = 1'b1; pulse(N'(1) << 11); tick(8);
        check(!pend_o[11] && !req_valid, "R4 masked", int'(pend_o[11]), 0);
        cfg_mask[11] = 1'b0; tick(8);
        check(!req_valid, "R4 unmask not held", int'(req_valid), 0);

        // R3 second edge while pending gives no second delivery
        pulse(N'(1) << 4);
        wait_offer(4, 37, "R3 first");
        pulse(N'(1) << 4); tick(6);
        accept(); tick(10);
        check(!req_valid && !pend_o[4], "R3 no repeat", int'(req_valid), 0);

        // R8 offer stable across config change
        pulse(N'(1) << 6);
        wait_offer(6, 55, "R8 offer");
        cfg_vec[6*VW +: VW] = 8'hAA; cfg_mode[6*3 +: 3] = 3'b111; tick(4);
        check(req_valid && req_line == 6 && req_vec == 55 && req_mode == 3'd2,
              "R8 held", int'(req_vec), 55);
        accept();
        cfg_vec[6*VW +: VW] = 8'd55; cfg_mode[6*3 +: 3] = 3'd2;

        // R7 rotation: place pointer at 10, fire 2, 5, 20 together
        pulse(N'(1) << 9);
        wait_offer(9, 82, "R7 setup");
        accept();
        pulse((N'(1) << 2) | (N'(1) << 5) | (N'(1) << 20));
        begin
            int left[3];
            left = '{2, 5, 20};
            for (int s = 0; s < 3; s++) begin
                int best = -1, bd = N + 1;
                for (int j = 0; j < 3; j++)
                    if (left[j] >= 0 && (left[j] - bp + N) % N < bd) begin
                        bd = (left[j] - bp + N) % N; best = j;
                    end
                wait_offer(left[best], (left[best] * 9 + 1) % 256, "R7 order");
                left[best] = -1;
                accept();
            end
        end

        // R5 R6 level line 7, vector 0x40
        cfg_level[7] = 1'b1; cfg_vec[7*VW +: VW] = 8'h40; cfg_mode[7*3 +: 3] = 3'b000;
        irq_in[7] = 1'b1;
        wait_offer(7, 8'h40, "R5 level");
        accept(); tick(6);
        check(rirr_o[7], "R6 rirr set", int'(rirr_o[7]), 1);
        check(!req_valid, "R5 blocked by rirr", int'(req_valid), 0);
        eoi(8'h41); tick(6);
        check(rirr_o[7] && !req_valid, "R6 wrong vector", int'(rirr_o[7]), 1);
        eoi(8'h40);
        check(!rirr_o[7], "R6 cleared", int'(rirr_o[7]), 0);
        wait_offer(7, 8'h40, "R5 repend");
        accept();
        irq_in[7] = 1'b0; tick(4); eoi(8'h40); tick(8);
        check(!req_valid && !pend_o[7], "R5 inactive", int'(req_valid), 0);
        cfg_level[7] = 1'b0;

        // R9 level bit with NMI mode acts as edge
        cfg_level[9] = 1'b1; cfg_mode[9*3 +: 3] = 3'b100;
        irq_in[9] = 1'b1;
        wait_offer(9, 82, "R9 nmi");
        check(req_mode == 3'b100, "R9 mode", int'(req_mode), 4);
        accept(); tick(8);
        check(!rirr_o[9] && !req_valid, "R9 once", int'(req_valid), 0);
        irq_in[9] = 1'b0; tick(4);
        cfg_level[9] = 1'b0; cfg_mode[9*3 +: 3] = 3'd1;

        // R10 bypass of line 23
        cfg_mask[23] = 1'b1; irq_in[23] = 1'b1; tick(3);
        check(!smi_n, "R10 smi low", int'(smi_n), 0);
        check(!pend_o[23], "R10 not pending", int'(pend_o[23]), 0);
        irq_in[23] = 1'b0; tick(3);
        check(smi_n, "R10 smi released", int'(smi_n), 1);
        cfg_mask[23] = 1'b0; tick(2);
        irq_in[23] = 1'b1; tick(3);
        check(smi_n, "R10 unmasked inactive", int'(smi_n), 1);
        irq_in[23] = 1'b0;
        wait_offer(23, 208, "R10 scanned");
        accept(); tick(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule